// File: doc/BRIEF.md
# Vertical-First Element Step Controller

This block keeps the element position of a vertical-first vector loop. Ordinary vectorised instructions each run one element group, chosen by a source step and a destination step that the block holds in registers. The steps move only when an explicit step command arrives. A vector length register sets where the loop ends. The block turns each operand base register into an effective register number. A vector-marked operand gets the matching step added to its base. A scalar-marked operand passes its base through unchanged.

The step command adds a fixed element count to both steps. If its record bit is set, the command also refreshes an equality condition flag that a branch can test to end the loop. The element count is captured when a loop starts, so it cannot change while the loop runs. A count register can also be decremented by that element count, saturating at zero, with a zero flag for the branch unit.

All pins are plain control and status. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. Decode, the register file and the branch unit stay outside the block and appear only as strobes and ports.

Top module: `vf_step_ctrl`

## Requirements
- R1: Reset sets vl, srcstep and dststep to 0, cond_eq to 0, ctr_val to 0 with ctr_zero at 1, and the stored element count to 1.
- R2: The effective register number is combinational. For each source operand it is base + srcstep when its vec bit is 1, and base when the bit is 0. The destination works the same way with dststep. All numbers are 7-bit. Source operand i occupies bits [7i+6:7i] of src_base and src_reg.
- R3: A cycle with no step_cmd, vl_wr or loop_rst leaves srcstep and dststep unchanged, whatever exec_en does. In a cycle where step_cmd and exec_en are both high, the addresses use the pre-increment step values.
- R4: When step_cmd is high and neither vl_wr nor loop_rst is, srcstep and dststep each increase by the stored element count (modulo 128) at the next clock edge.
- R5: A step_cmd with step_rc high sets cond_eq at the next edge: 1 if the new srcstep equals vl, 0 otherwise. cond_eq holds its value in every other cycle, including a step_cmd without step_rc.
- R6: vl_wr loads vl with min(vl_wdata, 64). vl_wr or loop_rst clears both steps at the next edge and captures elem_cnt_in as the element count, with a value of 0 stored as 1. Either one takes priority over step_cmd in the same cycle, and that step command is dropped.
- R7: addr_err is 1 exactly when exec_en is 1 and some operand's unwrapped base + offset exceeds 127.
- R8: ctr_wr loads ctr_val with ctr_wdata. Otherwise ctr_dec subtracts the stored element count, saturating at 0. With neither strobe, ctr_val holds.
- R9: ctr_zero is 1 exactly when ctr_val is 0.
- R10: Changing elem_cnt_in while a loop runs has no effect on the step size until the next vl_wr or loop_rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vl_wr | input | 1 | Write the vector length; restarts the loop |
| vl_wdata | input | 7 | Requested vector length (clamped to 64) |
| loop_rst | input | 1 | Restart the loop without changing vl |
| elem_cnt_in | input | 3 | Elements per instruction, captured at loop start |
| step_cmd | input | 1 | Explicit step command pulse |
| step_rc | input | 1 | Record bit of the step command |
| exec_en | input | 1 | An element-executing instruction is issued this cycle |
| src_base | input | 14 | Base register numbers of the two source operands |
| src_vec | input | 2 | Vector marks of the source operands |
| dst_base | input | 7 | Base register number of the destination |
| dst_vec | input | 1 | Vector mark of the destination |
| ctr_wr | input | 1 | Load the count register |
| ctr_wdata | input | 16 | Count register load value |
| ctr_dec | input | 1 | Decrement the count register by the element count |
| srcstep | output | 7 | Current source step |
| dststep | output | 7 | Current destination step |
| vl | output | 7 | Current vector length |
| cond_eq | output | 1 | End-of-loop condition flag |
| src_reg | output | 14 | Effective source register numbers |
| dst_reg | output | 7 | Effective destination register number |
| addr_err | output | 1 | Effective register number out of range |
| ctr_val | output | 16 | Count register |
| ctr_zero | output | 1 | Count register is zero |

## Verification
The hardest states to reach are the end-of-loop flag turning to 1 and the out-of-range error on a vector operand. Random loop restarts keep the steps small, so the steps rarely reach vl or climb high enough to overflow a large base. Directed sequences therefore run a loop with the record bit set until srcstep reaches vl, including an element count of 2 against an odd vl so the flag never rises. Further directed steps drive the steps past 64 so that high bases overflow. A stepping run that changes elem_cnt_in mid-loop shows the captured count is kept. The same-cycle collisions of a restart with a step command, and of a count load with a decrement, come from the random mix.

// File: rtl/vf_step_pkg.sv
package vf_step_pkg;
  localparam int STEP_W = 7;
  localparam int REG_W  = 7;
  localparam int VL_MAX = 64;
  localparam int CNT_W  = 3;
  localparam int CTR_W  = 16;
  localparam int NSRC   = 2;
endpackage

// File: rtl/vf_step_regs.sv
module vf_step_regs
  import vf_step_pkg::*;
#(
  parameter int SW   = STEP_W,
  parameter int CW   = CNT_W,
  parameter int VMAX = VL_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vl_wr,
  input  logic [SW-1:0] vl_wdata,
  input  logic          loop_rst,
  input  logic [CW-1:0] elem_cnt_in,
  input  logic          step_cmd,
  input  logic          step_rc,
  output logic [SW-1:0] srcstep,
  output logic [SW-1:0] dststep,
  output logic [SW-1:0] vl,
  output logic          cond_eq,
  output logic [CW-1:0] elem_cnt
);
  localparam logic [SW-1:0] VMAX_V = SW'(VMAX);

  logic          restart;
  logic [SW-1:0] src_nx, dst_nx, vl_clamped;
  logic [CW-1:0] cnt_capt;

  always_comb begin
    restart    = vl_wr | loop_rst;
    src_nx     = srcstep + SW'(elem_cnt);
    dst_nx     = dststep + SW'(elem_cnt);
    vl_clamped = (vl_wdata > VMAX_V) ? VMAX_V : vl_wdata;
    cnt_capt   = (elem_cnt_in == '0) ? CW'(1) : elem_cnt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcstep  <= '0;
      dststep  <= '0;
      vl       <= '0;
      cond_eq  <= 1'b0;
      elem_cnt <= CW'(1);
    end else begin
      if (vl_wr) vl <= vl_clamped;
      if (restart) begin
        srcstep  <= '0;
        dststep  <= '0;
        elem_cnt <= cnt_capt;
      end else if (step_cmd) begin
        srcstep <= src_nx;
        dststep <= dst_nx;
        if (step_rc) cond_eq <= (src_nx == vl);
      end
    end
  end

  p_step_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cmd && !restart) |=> (srcstep == SW'($past(srcstep) + SW'($past(elem_cnt)))));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_cmd && !restart) |=> ($stable(srcstep) && $stable(dststep)));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (srcstep == '0 && dststep == '0));
  p_vl_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vl <= VMAX_V);
  p_eq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_cmd && step_rc && !restart) |=> $stable(cond_eq));
  p_cnt_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(elem_cnt));
endmodule

// File: rtl/vf_addr_gen.sv
module vf_addr_gen
  import vf_step_pkg::*;
#(
  parameter int SW = STEP_W,
  parameter int RW = REG_W
) (
  input  logic [RW-1:0] base,
  input  logic          vec,
  input  logic [SW-1:0] step,
  output logic [RW-1:0] reg_num,
  output logic          oor
);
  logic [RW:0] sum;

  always_comb begin
    sum     = {1'b0, base} + (vec ? (RW+1)'(step) : '0);
    reg_num = sum[RW-1:0];
    oor     = sum[RW];
  end
endmodule

// File: rtl/vf_ctr_unit.sv
module vf_ctr_unit
  import vf_step_pkg::*;
#(
  parameter int TW = CTR_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctr_wr,
  input  logic [TW-1:0] ctr_wdata,
  input  logic          ctr_dec,
  input  logic [CW-1:0] elem_cnt,
  output logic [TW-1:0] ctr_val,
  output logic          ctr_zero
);
  logic [TW-1:0] dec_amt;
  logic          under;

  always_comb begin
    dec_amt  = TW'(elem_cnt);
    under    = (ctr_val < dec_amt);
    ctr_zero = (ctr_val == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctr_val <= '0;
    else if (ctr_wr)  ctr_val <= ctr_wdata;
    else if (ctr_dec) ctr_val <= under ? '0 : (ctr_val - dec_amt);
  end

  p_ctr_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_dec && !ctr_wr && ctr_val < TW'(elem_cnt)) |=> (ctr_val == '0));
  p_ctr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctr_wr && !ctr_dec) |=> $stable(ctr_val));
  p_ctr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_wr |=> (ctr_val == $past(ctr_wdata)));
endmodule

// File: rtl/vf_step_ctrl.sv
module vf_step_ctrl
  import vf_step_pkg::*;
#(
  parameter int SW   = STEP_W,
  parameter int RW   = REG_W,
  parameter int CW   = CNT_W,
  parameter int TW   = CTR_W,
  parameter int NS   = NSRC,
  parameter int VMAX = VL_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vl_wr,
  input  logic [SW-1:0]    vl_wdata,
  input  logic             loop_rst,
  input  logic [CW-1:0]    elem_cnt_in,
  input  logic             step_cmd,
  input  logic             step_rc,
  input  logic             exec_en,
  input  logic [NS*RW-1:0] src_base,
  input  logic [NS-1:0]    src_vec,
  input  logic [RW-1:0]    dst_base,
  input  logic             dst_vec,
  input  logic             ctr_wr,
  input  logic [TW-1:0]    ctr_wdata,
  input  logic             ctr_dec,
  output logic [SW-1:0]    srcstep,
  output logic [SW-1:0]    dststep,
  output logic [SW-1:0]    vl,
  output logic             cond_eq,
  output logic [NS*RW-1:0] src_reg,
  output logic [RW-1:0]    dst_reg,
  output logic             addr_err,
  output logic [TW-1:0]    ctr_val,
  output logic             ctr_zero
);
  logic [CW-1:0] elem_cnt;
  logic [NS-1:0] src_oor;
  logic          dst_oor;

  vf_step_regs #(.SW(SW), .CW(CW), .VMAX(VMAX)) u_regs (
    .clk(clk), .rst_n(rst_n), .vl_wr(vl_wr), .vl_wdata(vl_wdata),
    .loop_rst(loop_rst), .elem_cnt_in(elem_cnt_in), .step_cmd(step_cmd),
    .step_rc(step_rc), .srcstep(srcstep), .dststep(dststep), .vl(vl),
    .cond_eq(cond_eq), .elem_cnt(elem_cnt)
  );

  for (genvar i = 0; i < NS; i++) begin : g_src
    vf_addr_gen #(.SW(SW), .RW(RW)) u_src (
      .base(src_base[i*RW +: RW]), .vec(src_vec[i]), .step(srcstep),
      .reg_num(src_reg[i*RW +: RW]), .oor(src_oor[i])
    );
  end

  vf_addr_gen #(.SW(SW), .RW(RW)) u_dst (
    .base(dst_base), .vec(dst_vec), .step(dststep),
    .reg_num(dst_reg), .oor(dst_oor)
  );

  assign addr_err = exec_en & ((|src_oor) | dst_oor);

  vf_ctr_unit #(.TW(TW), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata),
    .ctr_dec(ctr_dec), .elem_cnt(elem_cnt), .ctr_val(ctr_val),
    .ctr_zero(ctr_zero)
  );

  p_scalar_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_vec |-> (dst_reg == dst_base));
  p_err_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |-> !addr_err);
endmodule

// File: tb/tb_vf_step_ctrl.sv
`timescale 1ns/1ps
module tb_vf_step_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vl_wr = 0, loop_rst = 0, step_cmd = 0, step_rc = 0, exec_en = 0;
  logic [6:0] vl_wdata = 0, dst_base = 0;
  logic [2:0] elem_cnt_in = 0;
  logic [13:0] src_base = 0;
  logic [1:0] src_vec = 0;
  logic dst_vec = 0, ctr_wr = 0, ctr_dec = 0;
  logic [15:0] ctr_wdata = 0;
  logic [6:0] srcstep, dststep, vl, dst_reg;
  logic [13:0] src_reg;
  logic cond_eq, addr_err, ctr_zero;
  logic [15:0] ctr_val;

  int n_chk = 0, n_fail = 0;
  int m_vl, m_src, m_dst, m_eq, m_cnt, m_ctr;
  string st_tag = "R1";

  always #10 clk = ~clk;

  vf_step_ctrl dut (
    .clk(clk), .rst_n(rst_n), .vl_wr(vl_wr), .vl_wdata(vl_wdata),
    .loop_rst(loop_rst), .elem_cnt_in(elem_cnt_in), .step_cmd(step_cmd),
    .step_rc(step_rc), .exec_en(exec_en), .src_base(src_base),
    .src_vec(src_vec), .dst_base(dst_base), .dst_vec(dst_vec),
    .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata), .ctr_dec(ctr_dec),
    .srcstep(srcstep), .dststep(dststep), .vl(vl), .cond_eq(cond_eq),
    .src_reg(src_reg), .dst_reg(dst_reg), .addr_err(addr_err),
    .ctr_val(ctr_val), .ctr_zero(ctr_zero)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int sum_of(input int base, input bit vec, input int step);
    return base + (vec ? step : 0);
  endfunction

  // Inputs are already set; check this cycle, then advance the model.
  task automatic cycle();
    int s0, s1, d, ns;
    string atag;
    #1;
    atag = (step_cmd && exec_en) ? "R3" : "R2";
    s0 = sum_of(src_base[6:0], src_vec[0], m_src);
    s1 = sum_of(src_base[13:7], src_vec[1], m_src);
    d  = sum_of(dst_base, dst_vec, m_dst);
    chk({st_tag, " srcstep"}, srcstep, m_src);
    chk({st_tag, " dststep"}, dststep, m_dst);
    chk("R6 vl", vl, m_vl);
    chk("R5 cond_eq", cond_eq, m_eq);
    chk("R8 ctr_val", ctr_val, m_ctr);
    chk("R9 ctr_zero", ctr_zero, (m_ctr == 0) ? 1 : 0);
    chk({atag, " src0"}, src_reg[6:0], s0 % 128);
    chk({atag, " src1"}, src_reg[13:7], s1 % 128);
    chk({atag, " dst"}, dst_reg, d % 128);
    chk("R7 addr_err", addr_err,
        (exec_en && (s0 > 127 || s1 > 127 || d > 127)) ? 1 : 0);
    // model update at the coming edge (counter uses the current count)
    if (ctr_wr) m_ctr = ctr_wdata;
    else if (ctr_dec) m_ctr = (m_ctr < m_cnt) ? 0 : m_ctr - m_cnt;
    if (vl_wr || loop_rst) begin
      if (vl_wr) m_vl = (vl_wdata > 64) ? 64 : vl_wdata;
      m_src = 0; m_dst = 0;
      m_cnt = (elem_cnt_in == 0) ? 1 : elem_cnt_in;
      st_tag = "R6";
    end else if (step_cmd) begin
      st_tag = (elem_cnt_in != m_cnt && elem_cnt_in != 0) ? "R10" : "R4";
      ns = (m_src + m_cnt) % 128;
      m_src = ns;
      m_dst = (m_dst + m_cnt) % 128;
      if (step_rc) m_eq = (ns == m_vl) ? 1 : 0;
    end else st_tag = "R3";
    @(negedge clk);
  endtask

  task automatic idle();
    vl_wr = 0; loop_rst = 0; step_cmd = 0; step_rc = 0;
    ctr_wr = 0; ctr_dec = 0; exec_en = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 srcstep", srcstep, 0); chk("R1 dststep", dststep, 0);
    chk("R1 vl", vl, 0); chk("R1 cond_eq", cond_eq, 0);
    chk("R1 ctr_val", ctr_val, 0); chk("R1 ctr_zero", ctr_zero, 1);
    m_vl = 0; m_src = 0; m_dst = 0; m_eq = 0; m_cnt = 1; m_ctr = 0;
    rst_n = 1'b1;

    // R6: clamp vl, count 0 stored as 1
    idle(); vl_wr = 1; vl_wdata = 7'd100; elem_cnt_in = 0; cycle();
    // R5: loop with record bit until srcstep reaches vl
    idle(); vl_wr = 1; vl_wdata = 7'd5; cycle();
    for (int i = 0; i < 6; i++) begin
      idle(); step_cmd = 1; step_rc = 1; exec_en = 1; src_vec = 2'b11;
      dst_vec = 1; src_base = {7'd10, 7'd20}; dst_base = 7'd30; cycle();
    end
    // R5: step without record bit keeps the flag
    idle(); step_cmd = 1; cycle();
    // R10: count 2 captured, later change of elem_cnt_in ignored; odd vl never hit
    idle(); vl_wr = 1; vl_wdata = 7'd7; elem_cnt_in = 3'd2; cycle();
    elem_cnt_in = 3'd5;
    for (int i = 0; i < 5; i++) begin
      idle(); step_cmd = 1; step_rc = 1; cycle();
    end
    // R7: drive steps past 64, overflow high bases
    idle(); loop_rst = 1; elem_cnt_in = 3'd7; cycle();
    for (int i = 0; i < 12; i++) begin
      idle(); step_cmd = 1; cycle();
    end
    idle(); exec_en = 1; src_vec = 2'b01; src_base = {7'd127, 7'd100};
    dst_vec = 0; dst_base = 7'd127; cycle();
    idle(); exec_en = 0; cycle();
    // R8 / R9: saturating decrement to zero
    idle(); ctr_wr = 1; ctr_wdata = 16'd10; cycle();
    for (int i = 0; i < 3; i++) begin idle(); ctr_dec = 1; cycle(); end
    idle(); ctr_wr = 1; ctr_dec = 1; ctr_wdata = 16'd3; cycle();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      vl_wr       = ($urandom_range(0, 99) < 4);
      loop_rst    = ($urandom_range(0, 99) < 3);
      vl_wdata    = 7'($urandom_range(0, 72));
      elem_cnt_in = 3'($urandom);
      step_cmd    = ($urandom_range(0, 99) < 45);
      step_rc     = $urandom_range(0, 1);
      exec_en     = $urandom_range(0, 1);
      src_vec     = 2'($urandom);
      dst_vec     = $urandom_range(0, 1);
      src_base    = {7'($urandom_range(90, 127)), 7'($urandom)};
      dst_base    = 7'($urandom);
      ctr_wr      = ($urandom_range(0, 99) < 5);
      ctr_wdata   = 16'($urandom_range(0, 40));
      ctr_dec     = ($urandom_range(0, 99) < 35);
      cycle();
    end
    idle(); cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule